// File: doc/BRIEF.md
# Sequential Page-Mode ROM Burst Reader

This controller sits on the system clock and fetches bursts of consecutive 16-bit words from a page-organised sequential ROM. The ROM shares one 16-bit bus for addresses and data. A client hands over a 22-bit start word address and a word count. The controller then loads the ROM address in two ordered bus phases: the upper part first, then the lower part. It waits out the long first-access latency. After that it strobes one word per read cycle and passes each word to a valid/ready stream.

The ROM only counts inside a 256-word page. The controller therefore tracks the running address. When a page is exhausted and words are still owed, it loads the address again from the start. When the burst is finished, it sends the ROM to standby and signals completion with a single-cycle `done` pulse. Every device delay is a cycle count, set by a parameter.

Top module: `seqrom_rd_ctrl`

## Requirements
- R1: Out of reset and whenever idle, `rom_en_n`=1, `rom_hlatch`=0, `rom_llatch`=0, `rom_strobe_n`=1, `rom_ad_oe`=0 and `dout_valid`=0. `req_ready` is 1 except in the cycle where `done` is high.
- R2: An address load starts with a high phase that lasts exactly T_ALE cycles. During it, `rom_hlatch`=1, `rom_llatch`=1, `rom_en_n`=0, `rom_ad_oe`=1 and `rom_ad_out`={9'b0, addr[21:15]}. `rom_hlatch` then falls while `rom_en_n` stays 0.
- R3: A low phase follows directly and lasts exactly T_ALE cycles. During it, `rom_hlatch`=0, `rom_llatch`=1 and `rom_ad_out`={addr[14:0], 1'b0}, so the page offset sits in bus bits 8:1. `rom_llatch` then falls. A low phase is never issued without a preceding high phase.
- R4: `rom_ad_oe` drops when `rom_llatch` falls. The first `rom_strobe_n` low after an address load comes no sooner than T_LAT cycles after that fall.
- R5: Each strobe holds `rom_strobe_n` low for exactly T_ACC cycles. Successive strobe falls are at least T_CYC cycles apart. `rom_ad_oe` is never 1 while `rom_strobe_n` is 0.
- R6: The word on `rom_ad_in` is captured in the last low cycle of each strobe. Words appear on `dout_data` in address order. While `dout_valid`=1 and `dout_ready`=0, `dout_valid` and `dout_data` hold.
- R7: A strobe never starts while an undelivered word is pending (`dout_valid`=0 at every strobe fall).
- R8: After the word at page offset 255, if words remain, both address phases are issued again for the next address. The 22-bit address wraps from 0x3FFFFF to 0.
- R9: At the end of a burst, the controller raises `rom_en_n` and holds `rom_hlatch` high with `rom_llatch` low for T_ALE cycles. `rom_hlatch` then falls with `rom_en_n` still high. `done` is then high for exactly one cycle.
- R10: A request with length 0 produces `done` in the next cycle with no activity on any ROM pin.
- R11: `req_ready` is 0 whenever `rom_en_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 22 | Start word address |
| req_len | input | 16 | Number of words to read |
| done | output | 1 | One-cycle pulse when a request has finished |
| rom_hlatch | output | 1 | Upper-address latch strobe (falling edge latches) |
| rom_llatch | output | 1 | Lower-address latch strobe (falling edge latches) |
| rom_en_n | output | 1 | Device enable, active low |
| rom_strobe_n | output | 1 | Read strobe, active low |
| rom_ad_out | output | 16 | Address value driven onto the shared bus |
| rom_ad_oe | output | 1 | Bus drive enable |
| rom_ad_in | input | 16 | Data returned from the shared bus |
| dout_valid | output | 1 | Output word available |
| dout_ready | input | 1 | Consumer accepts the output word |
| dout_data | output | 16 | Output word |

## Verification
The assertions assume that `rst_n` is held for several cycles and that a request is offered only when `req_ready` is high. They also assume the consumer is free to stall `dout_ready` for any length of time. The latency and spacing properties further assume the ROM gives no response other than through `rom_ad_in`. The stimulus respects these assumptions: it raises `req_valid` for one cycle only after seeing `req_ready` high, it drives `dout_ready` from fixed or pseudo-random patterns, and it answers from a behavioural ROM model. That model puts a marker value on `rom_ad_in` until T_ACC-1 cycles after each strobe fall, so a capture made one cycle early returns the wrong word.

// File: rtl/seqrom_pkg.sv
package seqrom_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HI,
      S_LO,
      S_LAT,
      S_RDL,
      S_RDH,
      S_PARK
   } seq_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/seqrom_timer.sv
module seqrom_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - W'(1);
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/seqrom_out_buf.sv
module seqrom_out_buf #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              free
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= din;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   assign free = !valid || ready;
endmodule

// File: rtl/seqrom_addr_fmt.sv
module seqrom_addr_fmt #(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [DATA_W-1:0] hi_word,
   output logic [DATA_W-1:0] lo_word
);
   localparam int LO_BITS = DATA_W - 1;
   localparam int HI_BITS = ADDR_W - LO_BITS;

   if (HI_BITS < 1 || HI_BITS > DATA_W) begin : g_bad_width
      $error("seqrom_addr_fmt: address width does not fit two bus phases");
   end

   assign lo_word = {cur[LO_BITS-1:0], 1'b0};

   if (HI_BITS == DATA_W) begin : g_hi_full
      assign hi_word = cur[ADDR_W-1:LO_BITS];
   end else begin : g_hi_pad
      assign hi_word = {{(DATA_W-HI_BITS){1'b0}}, cur[ADDR_W-1:LO_BITS]};
   end
endmodule

// File: rtl/seqrom_rd_ctrl.sv
module seqrom_rd_ctrl
   import seqrom_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int LEN_W     = 16,
   parameter int DATA_W    = 16,
   parameter int PAGE_BITS = 8,
   parameter int T_ALE     = 4,
   parameter int T_LAT     = 48,
   parameter int T_CYC     = 10,
   parameter int T_ACC     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              done,
   output logic              rom_hlatch,
   output logic              rom_llatch,
   output logic              rom_en_n,
   output logic              rom_strobe_n,
   output logic [DATA_W-1:0] rom_ad_out,
   output logic              rom_ad_oe,
   input  logic [DATA_W-1:0] rom_ad_in,
   output logic              dout_valid,
   input  logic              dout_ready,
   output logic [DATA_W-1:0] dout_data
);
   localparam int MAXT  = imax(imax(T_ALE, T_LAT), imax(T_CYC, T_ACC));
   localparam int TMR_W = $clog2(MAXT + 1);
   localparam logic [TMR_W-1:0] V_ALE = TMR_W'(T_ALE - 1);
   localparam logic [TMR_W-1:0] V_LAT = TMR_W'(T_LAT - 1);
   localparam logic [TMR_W-1:0] V_ACC = TMR_W'(T_ACC - 1);
   localparam logic [TMR_W-1:0] V_GAP = TMR_W'(T_CYC - T_ACC - 1);

   if (T_ALE < 1 || T_LAT < 1 || T_ACC < 1) begin : g_bad_delay
      $error("seqrom_rd_ctrl: every delay count must be at least one cycle");
   end
   if (T_CYC <= T_ACC) begin : g_bad_cycle
      $error("seqrom_rd_ctrl: read cycle must exceed access count");
   end
   if (PAGE_BITS < 1 || PAGE_BITS > DATA_W - 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("seqrom_rd_ctrl: page offset width out of range");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("seqrom_rd_ctrl: length width must be positive");
   end

   seq_state_t        st, nxt;
   logic [ADDR_W-1:0] cur;
   logic [LEN_W-1:0]  rem;
   logic              done_q;
   logic              accept;
   logic              tmr_load, tmr_exp;
   logic [TMR_W-1:0]  tmr_val;
   logic              cap, out_free;
   logic [DATA_W-1:0] hi_word, lo_word;

   assign req_ready = (st == S_IDLE) && !done_q;
   assign accept    = req_valid && req_ready;
   assign done      = done_q;

   seqrom_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   seqrom_out_buf #(.DATA_W(DATA_W)) u_obuf (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cap),
      .din   (rom_ad_in),
      .ready (dout_ready),
      .valid (dout_valid),
      .data  (dout_data),
      .free  (out_free)
   );

   seqrom_addr_fmt #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_afmt (
      .cur     (cur),
      .hi_word (hi_word),
      .lo_word (lo_word)
   );

   always_comb begin
      nxt      = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      cap      = 1'b0;
      case (st)
         S_IDLE: if (accept && req_len != '0) begin
            nxt = S_HI; tmr_load = 1'b1; tmr_val = V_ALE;
         end
         S_HI: if (tmr_exp) begin
            nxt = S_LO; tmr_load = 1'b1; tmr_val = V_ALE;
         end
         S_LO: if (tmr_exp) begin
            nxt = S_LAT; tmr_load = 1'b1; tmr_val = V_LAT;
         end
         S_LAT: if (tmr_exp && out_free) begin
            nxt = S_RDL; tmr_load = 1'b1; tmr_val = V_ACC;
         end
         S_RDL: if (tmr_exp) begin
            cap = 1'b1; nxt = S_RDH; tmr_load = 1'b1; tmr_val = V_GAP;
         end
         S_RDH: if (tmr_exp) begin
            if (rem == '0) begin
               nxt = S_PARK; tmr_load = 1'b1; tmr_val = V_ALE;
            end else if (cur[PAGE_BITS-1:0] == '0) begin
               nxt = S_HI; tmr_load = 1'b1; tmr_val = V_ALE;
            end else if (out_free) begin
               nxt = S_RDL; tmr_load = 1'b1; tmr_val = V_ACC;
            end
         end
         S_PARK: if (tmr_exp) nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cur    <= '0;
         rem    <= '0;
         done_q <= 1'b0;
      end else begin
         st     <= nxt;
         done_q <= ((st == S_PARK) && tmr_exp) ||
                   ((st == S_IDLE) && accept && req_len == '0);
         if ((st == S_IDLE) && accept) begin
            cur <= req_addr;
            rem <= req_len;
         end else if (cap) begin
            cur <= cur + ADDR_W'(1);
            rem <= rem - LEN_W'(1);
         end
      end
   end

   assign rom_hlatch   = (st == S_HI) || (st == S_PARK);
   assign rom_llatch   = (st == S_HI) || (st == S_LO);
   assign rom_en_n     = (st == S_IDLE) || (st == S_PARK);
   assign rom_strobe_n = (st != S_RDL);
   assign rom_ad_oe    = (st == S_HI) || (st == S_LO);
   assign rom_ad_out   = (st == S_HI) ? hi_word :
                         (st == S_LO) ? lo_word : '0;
endmodule

// File: rtl/seqrom_rd_ctrl_chk.sv
module seqrom_rd_ctrl_chk #(
   parameter int DATA_W = 16,
   parameter int T_LAT  = 48,
   parameter int T_CYC  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              rom_hlatch,
   input logic              rom_llatch,
   input logic              rom_en_n,
   input logic              rom_strobe_n,
   input logic              rom_ad_oe,
   input logic              dout_valid,
   input logic              dout_ready,
   input logic [DATA_W-1:0] dout_data
);
   logic hl_q, ll_q, sb_q, lat_pend, sb_seen;
   int   since_ll, since_sb;
   logic hl_fall, ll_fall, sb_fall;

   assign hl_fall = hl_q && !rom_hlatch;
   assign ll_fall = ll_q && !rom_llatch;
   assign sb_fall = sb_q && !rom_strobe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hl_q <= 1'b0; ll_q <= 1'b0; sb_q <= 1'b1;
         lat_pend <= 1'b0; sb_seen <= 1'b0;
         since_ll <= 0; since_sb <= 0;
      end else begin
         hl_q <= rom_hlatch;
         ll_q <= rom_llatch;
         sb_q <= rom_strobe_n;
         if (ll_fall) begin
            since_ll <= 1; lat_pend <= 1'b1;
         end else if (since_ll < T_LAT) begin
            since_ll <= since_ll + 1;
         end
         if (sb_fall) begin
            since_sb <= 1; sb_seen <= 1'b1; lat_pend <= 1'b0;
         end else if (since_sb < T_CYC) begin
            since_sb <= since_sb + 1;
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> rom_en_n && rom_strobe_n && !rom_ad_oe && !rom_hlatch && !rom_llatch); // R1
   AST_HLATCH_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      hl_fall |-> (rom_llatch != rom_en_n)); // R2
   AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ll_fall |-> !rom_hlatch && !rom_en_n && !rom_ad_oe); // R3
   AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_fall && lat_pend) |-> since_ll >= T_LAT); // R4
   AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_fall && sb_seen) |-> since_sb >= T_CYC); // R5
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_strobe_n |-> !rom_ad_oe); // R5
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && !dout_ready) |=> dout_valid && $stable(dout_data)); // R6
   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sb_fall |-> !dout_valid); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_en_n |-> !req_ready); // R11
endmodule

bind seqrom_rd_ctrl seqrom_rd_ctrl_chk #(
   .DATA_W (DATA_W),
   .T_LAT  (T_LAT),
   .T_CYC  (T_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .done         (done),
   .rom_hlatch   (rom_hlatch),
   .rom_llatch   (rom_llatch),
   .rom_en_n     (rom_en_n),
   .rom_strobe_n (rom_strobe_n),
   .rom_ad_oe    (rom_ad_oe),
   .dout_valid   (dout_valid),
   .dout_ready   (dout_ready),
   .dout_data    (dout_data)
);

// File: tb/seqrom_rd_ctrl_tb.sv
module seqrom_rd_ctrl_tb;
   localparam int T_ALE = 4;
   localparam int T_LAT = 48;
   localparam int T_CYC = 10;
   localparam int T_ACC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [21:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        done;
   logic        rom_hlatch, rom_llatch, rom_en_n, rom_strobe_n, rom_ad_oe;
   logic [15:0] rom_ad_out;
   logic [15:0] rom_ad_in = '0;
   logic        dout_valid;
   logic        dout_ready = 1'b0;
   logic [15:0] dout_data;

   always #10 clk = ~clk;

   seqrom_rd_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .done(done),
      .rom_hlatch(rom_hlatch), .rom_llatch(rom_llatch),
      .rom_en_n(rom_en_n), .rom_strobe_n(rom_strobe_n),
      .rom_ad_out(rom_ad_out), .rom_ad_oe(rom_ad_oe), .rom_ad_in(rom_ad_in),
      .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data)
   );

   int compared = 0;
   int mismatched = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] romf(input logic [21:0] a);
      return a[15:0] ^ {a[21:16], 10'h0} ^ 16'h5A3C;
   endfunction

   logic [21:0] seg_q[$];
   logic [15:0] word_q[$];
   int          ready_mode = 0;
   int          hl_rises = 0;

   logic        p_hl = 1'b0, p_ll = 1'b0, p_sb = 1'b1;
   logic [15:0] p_ad = '0;
   logic [6:0]  m_hi = '0, m_plo = '0;
   logic [7:0]  m_off = '0;
   bit          m_hi_ok = 0, m_active = 0, m_standby = 1, first_rd = 0;
   int          hl_len = 0, ll_len = 0, since_ll = 0, since_sb = 1000, sb_low = 0;
   logic        p_vld = 1'b0, p_rdy = 1'b0;
   logic [15:0] p_data = '0;
   logic [21:0] wa = '0;

   // Behavioural ROM and reference model, evaluated away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic        nr;
         logic [21:0] e;
         since_sb++;
         if (p_vld && !p_rdy)
            chk(dout_valid && dout_data == p_data, "R6 hold under stall", dout_data, p_data);
         if (!p_hl && rom_hlatch) hl_rises++;
         if (p_hl && !rom_hlatch) begin
            chk(hl_len == T_ALE, "R2 hlatch high time", hl_len, T_ALE);
            if (!rom_en_n) begin
               chk(rom_llatch && p_ad[15:7] == 9'h0, "R2 high word", p_ad, {9'h0, p_ad[6:0]});
               m_hi = p_ad[6:0]; m_hi_ok = 1;
            end else begin
               chk(!rom_llatch, "R9 park with llatch low", rom_llatch, 0);
               m_standby = 1; m_active = 0; m_hi_ok = 0;
            end
         end
         if (p_ll && !rom_llatch) begin
            chk(m_hi_ok && !rom_hlatch, "R3 high phase first", m_hi_ok, 1);
            chk(ll_len == T_ALE, "R3 low phase time", ll_len, T_ALE);
            chk(!rom_ad_oe, "R4 bus released", rom_ad_oe, 0);
            m_plo = p_ad[15:9]; m_off = p_ad[8:1];
            if (seg_q.size() == 0) begin
               chk(0, "R8 unexpected address load", {m_hi, m_plo, m_off}, 0);
            end else begin
               e = seg_q.pop_front();
               chk({m_hi, m_plo, m_off} == e, "R8 segment address", {m_hi, m_plo, m_off}, e);
            end
            m_active = 1; m_standby = 0; m_hi_ok = 0; since_ll = 0; first_rd = 1;
         end else begin
            since_ll++;
         end
         if (p_sb && !rom_strobe_n) begin
            chk(m_active, "R4 strobe only when active", m_active, 1);
            if (first_rd) chk(since_ll >= T_LAT, "R4 first latency", since_ll, T_LAT);
            else          chk(since_sb >= T_CYC, "R5 strobe spacing", since_sb, T_CYC);
            chk(!dout_valid, "R7 no overwrite", dout_valid, 0);
            first_rd = 0; wa = {m_hi, m_plo, m_off}; m_off = m_off + 8'd1;
            since_sb = 0; sb_low = 0;
         end else if (!rom_strobe_n) begin
            sb_low++;
         end
         if (!p_sb && rom_strobe_n) chk(sb_low == T_ACC - 1, "R5 strobe low time", sb_low + 1, T_ACC);
         chk(!(!rom_strobe_n && rom_ad_oe), "R5 bus contention", rom_ad_oe, 0);
         if (!rom_en_n) chk(!req_ready, "R11 ready while busy", req_ready, 0);
         rom_ad_in = (!rom_strobe_n && sb_low >= T_ACC - 1) ? romf(wa) : (16'hBAD0 ^ 16'(sb_low));
         case (ready_mode)
            0: nr = 1'b1;
            1: nr = ($urandom % 4) != 0;
            default: nr = ($urandom % 4) == 0;
         endcase
         dout_ready = nr;
         if (dout_valid && nr) begin
            if (word_q.size() == 0) begin
               chk(0, "R6 unexpected word", dout_data, 0);
            end else begin
               logic [15:0] w;
               w = word_q.pop_front();
               chk(dout_data == w, "R6 word order", dout_data, w);
            end
         end
         p_vld = dout_valid; p_rdy = nr; p_data = dout_data;
         p_hl = rom_hlatch; p_ll = rom_llatch; p_sb = rom_strobe_n; p_ad = rom_ad_out;
         if (rom_hlatch) hl_len++; else hl_len = 0;
         if (rom_llatch && !rom_hlatch) ll_len++; else ll_len = 0;
      end
   end

   task automatic check_idle(input string tag);
      chk(rom_en_n && !rom_hlatch && !rom_llatch && rom_strobe_n && !rom_ad_oe,
          tag, {rom_en_n, rom_hlatch, rom_llatch, rom_strobe_n, rom_ad_oe}, 5'b10010);
   endtask

   task automatic run(input logic [21:0] addr, input int len, input int mode);
      logic [21:0] a;
      int          n, rises0;
      while (!req_ready) @(negedge clk);
      ready_mode = mode;
      a = addr;
      if (len > 0) seg_q.push_back(a);
      for (int i = 0; i < len; i++) begin
         word_q.push_back(romf(a));
         a = a + 22'd1;
         if (i < len - 1 && a[7:0] == 8'h00) seg_q.push_back(a);
      end
      rises0 = hl_rises;
      req_addr = addr; req_len = 16'(len); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (len == 0) begin
         chk(done, "R10 zero length done", done, 1);
         @(negedge clk);
         chk(hl_rises == rises0 && rom_en_n, "R10 no pin activity", hl_rises - rises0, 0);
      end else begin
         n = 0;
         while (!done && n < 20000) begin @(negedge clk); n++; end
         chk(done, "R9 done seen", done, 1);
         @(negedge clk);
         chk(!done, "R9 done one cycle", done, 0);
         chk(m_standby, "R9 standby entered", m_standby, 1);
         check_idle("R9 parked pins");
         ready_mode = 0;
         n = 0;
         while (word_q.size() != 0 && n < 100) begin @(negedge clk); n++; end
         @(negedge clk);
         chk(word_q.size() == 0, "R6 all words delivered", word_q.size(), 0);
         chk(seg_q.size() == 0, "R8 all address loads seen", seg_q.size(), 0);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check_idle("R1 pins in reset");
      chk(!dout_valid && req_ready, "R1 stream in reset", {dout_valid, req_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 pins after reset");
      run(22'h012345, 5, 0);
      run(22'h0456FC, 10, 0);
      run(22'h1ABC80, 300, 1);
      run(22'h3FFFFE, 4, 2);
      run(22'h000000, 0, 0);
      run(22'h2000FF, 1, 0);
      run(22'h2000FF, 2, 1);
      run(22'h155500, 20, 2);
      check_idle("R1 pins at end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule